// File: doc/BRIEF.md
# Retimer Initialization Handshake Controller

This block is the register-side half of a power-up handshake. After reset a shared serial master belongs to an on-chip initialization agent, and the host may not touch it until that agent has brought up two retimers. The host asks for the bring-up by setting a start bit in the init register. The same write carries eight 2-bit forward error correction (FEC) requests, four links per retimer. The block latches those requests and runs a stand-in initialization that lasts a programmable number of cycles. It then raises the done bit, fills in a status word for each retimer and passes ownership of the serial master to the host.

Each status word holds a group code and a mode ID. A group code of zero means the retimer came up cleanly. An injected failure puts a nonzero group code into the status of the selected retimer, but done is still raised, so the host always gets the serial master back. The FEC each link actually uses is driven on an output. It is zero for modes that run at 10G only. A build whose firmware version constant is zero stands for missing firmware: it hands the master to the host at once and never runs the handshake.

Top module: `retimer_init_ctrl`

## Requirements
- R1: During and after reset, the init register (0x1000) and both status registers read 0, `link_fec_o` is 0 and `host_own_o` is 0. Exception: a build with a zero version constant holds `host_own_o` at 1.
- R2: The version register (0x1004) returns the `FW_VERSION` parameter. Its fields are major in bits 31:28, minor in 27:24 and patch in 23:20. Writes to it have no effect.
- R3: A write to 0x1000 with bit 1 set, made while start and done are both clear, is accepted. It sets start (bit 1) and captures write bits 23:8 as the FEC requests, with link k at bits 9+2k:8+2k. Links 0-3 belong to retimer A and links 4-7 to retimer B. Codes: 0 no FEC, 1 KR, 2 RS. Done (bit 0) becomes visible exactly max(`init_len_i`,1) clock cycles after the accepting edge.
- R4: A write to 0x1000 that clears bit 1, or that arrives while start or done is already set, changes nothing: not the captured requests, not the completion time, not the status. Bit 0 cannot be written by the host.
- R5: At completion the status register of retimer A (0x1020) and of retimer B (0x1024) load their mode ID in bits 7:0 from `mode_a_i` / `mode_b_i`, sampled on the completing edge, with group code 0 in bits 15:8. They then hold that value until reset.
- R6: If `fail_i` is high on the completing edge, the retimer picked by `fail_sel_i` (0 = A, 1 = B) gets group code `FAIL_GROUP` (nonzero) and the other retimer gets 0. Done and `host_own_o` still rise.
- R7: `link_fec_o[2k+1:2k]` is 0 before done. After done it equals the captured request of link k when that link's retimer mode ID is 2, 3, 4 or 5. It is 0 for mode ID 0 (reset) or 1 (4x10G).
- R8: `host_own_o` rises in the same cycle as done and stays high until reset.
- R9: With `FW_VERSION` = 0, `host_own_o` is high from reset onward, start writes are ignored and the init register keeps reading 0.
- R10: A read strobe returns data on `reg_rdata_o` with `reg_rvalid_o` high in the cycle after the strobe. An unmapped address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | ADDR_W | Byte address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, registered |
| reg_rvalid_o | output | 1 | Read data valid |
| init_len_i | input | CNT_W | Stand-in initialization length in cycles (0 acts as 1) |
| mode_a_i | input | 8 | Mode ID reported for retimer A |
| mode_b_i | input | 8 | Mode ID reported for retimer B |
| fail_i | input | 1 | Inject a configuration failure at completion |
| fail_sel_i | input | 1 | Retimer that takes the failure (0 = A, 1 = B) |
| link_fec_o | output | 16 | Effective FEC per link, 2 bits each |
| host_own_o | output | 1 | Host owns the serial master |

## Verification
The bench counts cycles from the accepting write to the first high `host_own_o`, with lengths of 0 and 5. A counter that is off by one, or that treats 0 as a very long wait, shifts that edge. It repeats start writes while the sequence is busy and after done, carrying different FEC codes. A design that restarts, or that relatches the requests, shows the wrong request field or a moved completion. Mode IDs 0 and 1 are mixed with FEC-capable modes across the two retimers, which catches FEC that is not gated or is gated on the wrong retimer. A failure is injected on each retimer in turn, to show that done still rises and that only the chosen group code is nonzero.

// File: rtl/rinit_pkg.sv
package rinit_pkg;
  localparam int unsigned NUM_RT       = 2;
  localparam int unsigned LINKS_PER_RT = 4;
  localparam int unsigned NUM_LINKS    = NUM_RT * LINKS_PER_RT;
  localparam int unsigned FEC_W        = 2;

  localparam logic [15:0] ADDR_INIT  = 16'h1000;
  localparam logic [15:0] ADDR_VER   = 16'h1004;
  localparam logic [15:0] ADDR_STS_A = 16'h1020;
  localparam logic [15:0] ADDR_STS_B = 16'h1024;

  typedef enum logic [1:0] {SEQ_IDLE, SEQ_BUSY, SEQ_DONE} seq_state_e;

  // FEC is meaningful only for modes with 25G lanes (IDs 2..5)
  function automatic logic fec_capable(input logic [7:0] mode);
    return (mode >= 8'd2) && (mode <= 8'd5);
  endfunction
endpackage

// File: rtl/rinit_seq.sv
module rinit_seq
  import rinit_pkg::*;
#(
  parameter int unsigned CNT_W      = 16,
  parameter bit          FW_PRESENT = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_req_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             accept_o,
  output logic             finish_o,
  output logic             busy_o,
  output logic             done_o
);
  seq_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;

  assign accept_o = FW_PRESENT && start_req_i && (state_q == SEQ_IDLE);
  assign finish_o = (state_q == SEQ_BUSY) && (cnt_q == CNT_W'(1));
  assign busy_o   = (state_q == SEQ_BUSY);
  assign done_o   = (state_q == SEQ_DONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        SEQ_IDLE: if (accept_o) begin
          state_q <= SEQ_BUSY;
          cnt_q   <= (len_i == '0) ? CNT_W'(1) : len_i;
        end
        SEQ_BUSY: begin
          if (cnt_q == CNT_W'(1)) state_q <= SEQ_DONE;
          else                    cnt_q   <= cnt_q - CNT_W'(1);
        end
        default: state_q <= SEQ_DONE;
      endcase
    end
  end

  a_r3_busy_cnt_live: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (cnt_q != '0));
  a_r3_finish_to_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    finish_o |=> done_o);
  a_r4_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (done_o && !busy_o));
endmodule

// File: rtl/rinit_status.sv
module rinit_status
  import rinit_pkg::*;
#(
  parameter logic [7:0] FAIL_GROUP = 8'hE1
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           finish_i,
  input  logic                           done_i,
  input  logic [NUM_RT-1:0][7:0]         mode_i,
  input  logic                           fail_i,
  input  logic                           fail_sel_i,
  input  logic [NUM_LINKS*FEC_W-1:0]     fec_req_i,
  output logic [NUM_RT-1:0][15:0]        sts_o,
  output logic [NUM_LINKS*FEC_W-1:0]     link_fec_o
);
  logic [NUM_RT-1:0][15:0] sts_q;
  logic [NUM_RT-1:0]       grp_nz;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_q <= '0;
    end else if (finish_i) begin
      for (int r = 0; r < NUM_RT; r++) begin
        sts_q[r][15:8] <= (fail_i && (int'(fail_sel_i) == r)) ? FAIL_GROUP : 8'h00;
        sts_q[r][7:0]  <= mode_i[r];
      end
    end
  end

  for (genvar r = 0; r < NUM_RT; r++) begin : g_rt
    assign grp_nz[r] = |sts_q[r][15:8];
  end

  for (genvar l = 0; l < NUM_LINKS; l++) begin : g_link
    assign link_fec_o[FEC_W*l +: FEC_W] =
      (done_i && fec_capable(sts_q[l / LINKS_PER_RT][7:0])) ? fec_req_i[FEC_W*l +: FEC_W] : '0;
  end

  assign sts_o = sts_q;

  a_r5_clear_before_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |-> (sts_q == '0));
  a_r5_frozen_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> $stable(sts_q));
  a_r6_single_fail_group: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grp_nz));
  a_r7_no_fec_before_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |-> (link_fec_o == '0));
endmodule

// File: rtl/retimer_init_ctrl.sv
module retimer_init_ctrl
  import rinit_pkg::*;
#(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned CNT_W      = 16,
  parameter logic [31:0] FW_VERSION = 32'h3120_0000,
  parameter logic [7:0]  FAIL_GROUP = 8'hE1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              reg_rvalid_o,
  input  logic [CNT_W-1:0]  init_len_i,
  input  logic [7:0]        mode_a_i,
  input  logic [7:0]        mode_b_i,
  input  logic              fail_i,
  input  logic              fail_sel_i,
  output logic [15:0]       link_fec_o,
  output logic              host_own_o
);
  localparam bit          NO_FW   = (FW_VERSION == 32'h0);
  localparam int unsigned FEC_LSB = 8;
  localparam int unsigned REQ_W   = NUM_LINKS * FEC_W;

  logic              hit_init, start_req, accept, finish, busy, done;
  logic [REQ_W-1:0]  fec_q;
  logic              own_q;
  logic [NUM_RT-1:0][15:0] sts;
  logic [NUM_RT-1:0][7:0]  modes;
  logic [31:0]       rd_mux;
  logic              unused_wdata;

  assign hit_init  = (reg_addr_i == ADDR_W'(ADDR_INIT));
  assign start_req = reg_wr_i && hit_init && reg_wdata_i[1];
  assign modes     = {mode_b_i, mode_a_i};
  assign unused_wdata = ^{reg_wdata_i[31:24], reg_wdata_i[7:2], reg_wdata_i[0]};

  rinit_seq #(.CNT_W(CNT_W), .FW_PRESENT(!NO_FW)) u_seq (
    .clk_i, .rst_ni,
    .start_req_i(start_req),
    .len_i      (init_len_i),
    .accept_o   (accept),
    .finish_o   (finish),
    .busy_o     (busy),
    .done_o     (done)
  );

  rinit_status #(.FAIL_GROUP(FAIL_GROUP)) u_status (
    .clk_i, .rst_ni,
    .finish_i  (finish),
    .done_i    (done),
    .mode_i    (modes),
    .fail_i    (fail_i),
    .fail_sel_i(fail_sel_i),
    .fec_req_i (fec_q),
    .sts_o     (sts),
    .link_fec_o(link_fec_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     fec_q <= '0;
    else if (accept) fec_q <= reg_wdata_i[FEC_LSB +: REQ_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     own_q <= NO_FW;
    else if (finish) own_q <= 1'b1;
  end
  assign host_own_o = own_q;

  always_comb begin
    rd_mux = '0;
    if      (reg_addr_i == ADDR_W'(ADDR_INIT))  rd_mux = {8'h00, fec_q, 6'h00, busy | done, done};
    else if (reg_addr_i == ADDR_W'(ADDR_VER))   rd_mux = FW_VERSION;
    else if (reg_addr_i == ADDR_W'(ADDR_STS_A)) rd_mux = {16'h0000, sts[0]};
    else if (reg_addr_i == ADDR_W'(ADDR_STS_B)) rd_mux = {16'h0000, sts[1]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reg_rvalid_o <= 1'b0;
      reg_rdata_o  <= '0;
    end else begin
      reg_rvalid_o <= reg_rd_i;
      if (reg_rd_i) reg_rdata_o <= rd_mux;
    end
  end

  a_r4_req_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy || done) |=> $stable(fec_q));
  a_r8_own_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |-> host_own_o);
  a_r8_own_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_own_o |=> host_own_o);
  a_r10_rvalid_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rd_i |=> reg_rvalid_o);

  if (NO_FW) begin : g_nofw
    a_r9_never_starts: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !busy && !done && host_own_o);
  end
endmodule

// File: tb/retimer_init_ctrl_tb.sv
`timescale 1ns/100ps
module retimer_init_ctrl_tb;
  localparam logic [31:0] FW   = 32'h3120_0000;
  localparam logic [7:0]  FGRP = 8'hE1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [15:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [15:0] len = '0;
  logic [7:0]  mode_a = '0, mode_b = '0;
  logic        fail = 1'b0, fail_sel = 1'b0;
  logic [31:0] rdata, rdata_nf;
  logic        rvalid, rvalid_nf;
  logic [15:0] lfec, lfec_nf;
  logic        own, own_nf;

  int tests = 0, fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  retimer_init_ctrl #(.FW_VERSION(FW), .FAIL_GROUP(FGRP)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_rd_i(rd), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .reg_rvalid_o(rvalid),
    .init_len_i(len), .mode_a_i(mode_a), .mode_b_i(mode_b), .fail_i(fail),
    .fail_sel_i(fail_sel), .link_fec_o(lfec), .host_own_o(own));

  retimer_init_ctrl #(.FW_VERSION(32'h0)) u_nofw (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_rd_i(rd), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata_nf), .reg_rvalid_o(rvalid_nf),
    .init_len_i(len), .mode_a_i(mode_a), .mode_b_i(mode_b), .fail_i(fail),
    .fail_sel_i(fail_sel), .link_fec_o(lfec_nf), .host_own_o(own_nf));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // scoreboard: driver pushes expected read data, monitor pops on rvalid
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      if (exp_q.size() == 0) check("R10 unexpected rvalid", 32'h1, 32'h0);
      else check(tag_q.pop_front(), rdata, exp_q.pop_front());
    end
  end

  task automatic reg_read(input logic [15:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    rd = 1'b1; addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic reg_write(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 host_own low in reset", {31'h0, own}, 32'h0);
    check("R9 no-fw host_own high in reset", {31'h0, own_nf}, 32'h1);
    rst_n = 1'b1;
  endtask

  function automatic logic [15:0] fec_word(input logic [1:0] c [8]);
    logic [15:0] w = '0;
    for (int k = 0; k < 8; k++) w[2*k +: 2] = c[k];
    return w;
  endfunction

  function automatic logic [15:0] exp_fec(input logic [15:0] w, input logic [7:0] ma, input logic [7:0] mb);
    logic [15:0] e = '0;
    for (int k = 0; k < 8; k++) begin
      logic [7:0] m = (k < 4) ? ma : mb;
      if (m >= 8'd2 && m <= 8'd5) e[2*k +: 2] = w[2*k +: 2];
    end
    return e;
  endfunction

  function automatic logic [31:0] start_word(input logic [15:0] f);
    return {8'h00, f, 8'h02};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] f;
    do_reset();
    // R1 reset state
    reg_read(16'h1000, 32'h0, "R1 init reg after reset");
    reg_read(16'h1020, 32'h0, "R1 status A after reset");
    reg_read(16'h1024, 32'h0, "R1 status B after reset");
    check("R1 link fec after reset", {16'h0, lfec}, 32'h0);
    // R2 version, read only
    reg_read(16'h1004, FW, "R2 version");
    reg_write(16'h1004, 32'hDEAD_BEEF);
    reg_read(16'h1004, FW, "R2 version after write");
    // R10 unmapped
    reg_read(16'h1008, 32'h0, "R10 unmapped address");
    // R4 write without start bit, with done bit attempt
    reg_write(16'h1000, 32'h00FF_FF01);
    reg_read(16'h1000, 32'h0, "R4 write without start ignored");
    check("R4 host_own after non-start write", {31'h0, own}, 32'h0);

    // R3 timing with length 5, modes A=4x25G(2), B=4x10G(1)
    f = fec_word('{2'd2, 2'd1, 2'd0, 2'd2, 2'd2, 2'd2, 2'd1, 2'd1});
    mode_a = 8'd2; mode_b = 8'd1; len = 16'd5;
    reg_write(16'h1000, start_word(f));
    repeat (4) @(negedge clk);
    check("R3 not done at len-1", {31'h0, own}, 32'h0);
    @(negedge clk);
    check("R3 done at len / R8 own rises", {31'h0, own}, 32'h1);
    check("R9 no-fw init reg ignores start", 32'h0, 32'h0);
    reg_read(16'h1000, {8'h00, f, 8'h03}, "R3 init reg after done");
    check("R9 no-fw init reg stays 0", rdata_nf, 32'h0);
    check("R9 no-fw host_own", {31'h0, own_nf}, 32'h1);
    reg_read(16'h1020, 32'h0000_0002, "R5 status A mode");
    reg_read(16'h1024, 32'h0000_0001, "R5 status B mode");
    check("R7 fec gated by 10G on B", {16'h0, lfec}, {16'h0, exp_fec(f, 8'd2, 8'd1)});
    // R4 start after done, R5 hold after mode change
    mode_a = 8'd5;
    reg_write(16'h1000, start_word(16'hFFFF));
    reg_read(16'h1000, {8'h00, f, 8'h03}, "R4 start after done ignored");
    reg_read(16'h1020, 32'h0000_0002, "R5 status A held");
    repeat (50) @(negedge clk);
    check("R8 host_own stays high", {31'h0, own}, 32'h1);

    // R3 length 0 acts as 1; A reset mode, B 1x25G
    do_reset();
    check("R8 host_own cleared by reset", {31'h0, own}, 32'h0);
    f = fec_word('{2'd2, 2'd2, 2'd2, 2'd2, 2'd2, 2'd2, 2'd2, 2'd2});
    mode_a = 8'd0; mode_b = 8'd5; len = 16'd0;
    @(negedge clk);
    wr = 1'b1; addr = 16'h1000; wdata = start_word(f);
    @(negedge clk);
    wr = 1'b0;
    check("R3 len0 not done at accept", {31'h0, own}, 32'h0);
    @(negedge clk);
    check("R3 len0 done after one cycle", {31'h0, own}, 32'h1);
    check("R7 fec gated by reset mode on A", {16'h0, lfec}, {16'h0, exp_fec(f, 8'd0, 8'd5)});

    // R4 start while busy; R6 failure on B
    do_reset();
    f = fec_word('{2'd1, 2'd1, 2'd1, 2'd1, 2'd1, 2'd1, 2'd1, 2'd1});
    mode_a = 8'd3; mode_b = 8'd4; len = 16'd20; fail = 1'b1; fail_sel = 1'b1;
    reg_write(16'h1000, start_word(f));
    reg_write(16'h1000, start_word(16'hAAAA));
    reg_read(16'h1000, {8'h00, f, 8'h02}, "R4 start while busy ignored");
    check("R7 no fec while busy", {16'h0, lfec}, 32'h0);
    repeat (30) @(negedge clk);
    check("R6 done despite failure", {31'h0, own}, 32'h1);
    reg_read(16'h1000, {8'h00, f, 8'h03}, "R4 requests kept after busy write");
    reg_read(16'h1020, 32'h0000_0003, "R6 status A ok");
    reg_read(16'h1024, {16'h0, FGRP, 8'h04}, "R6 status B failed group");
    check("R7 fec both capable", {16'h0, lfec}, {16'h0, exp_fec(f, 8'd3, 8'd4)});

    // R6 failure on A
    do_reset();
    fail_sel = 1'b0; len = 16'd3; mode_a = 8'd1; mode_b = 8'd2;
    reg_write(16'h1000, start_word(16'h0));
    repeat (5) @(negedge clk);
    reg_read(16'h1020, {16'h0, FGRP, 8'h01}, "R6 status A failed group");
    reg_read(16'h1024, 32'h0000_0002, "R6 status B ok");
    fail = 1'b0;

    repeat (3) @(negedge clk);
    check("R10 scoreboard drained", exp_q.size(), 32'h0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule